// File: doc/BRIEF.md
# UART Interrupt Cause Controller

This block sits beside a UART's receive and transmit FIFOs and turns their fill levels, their push and pop strobes, the receiver's per-character error flags, the transmitter's busy flag and the clear-to-send input into seven interrupt causes. Some causes are live comparisons: the RX level, the TX level and TX empty. Others are sticky flags that hold an event until it is cleared: the RX error, the TX error and the CTS change. The receive timeout is measured in baud ticks against a character time taken from the live frame configuration.

Software sees the raw cause vector on `status`. It picks the causes it wants with `irq_en`, and `irq` carries the registered OR of the enabled causes. The sticky flags are cleared by write-one-to-clear strobes on `clr_w1c`. The two FIFO flush strobes, `rx_flush` and `tx_flush`, act independently, and each one also clears the status conditions that belong to its own side. The serial shifters and the FIFO storage are outside this block and appear only as input signals.

Top module: `uart_irq_ctrl`

## Requirements
- R1: `status[0]` (RX level) is 1 exactly while `rx_count >= rx_trig`, in the same cycle as the inputs.
- R2: `status[3]` (TX level) is 1 exactly while `tx_count <= tx_trig`; this is the request to refill the TX FIFO.
- R3: `status[2]` (RX timeout) is 1 when `rx_count` is non-zero and four character times of baud ticks have passed with no `rx_push`, `rx_pop` or `rx_flush`. One character time is (1 + (5 + `cfg_wlen`) + `cfg_par_en` + (1 + `cfg_stop2`)) ticks, multiplied by 8 when `cfg_os8` is 1 and by 16 otherwise. The bit rises in the cycle after the edge that takes in the last tick of that window. A push, pop or flush restarts the window, and the bit stays 0 while `rx_count` is 0.
- R4: `status[5]` (TX empty) is 1 only while `tx_count` is 0 and `tx_busy` is 0.
- R5: `status[1]` (RX error) is the OR of two sticky flags. The line-error flag is set by `rx_frame_err`, `rx_par_err` or `rx_brk_err`, and `clr_w1c[0]` clears it. The overrun flag is set by `rx_overrun`, and `clr_w1c[1]` clears it. Each clear bit leaves the other flag untouched.
- R6: `status[4]` (TX error) is a sticky flag. It is set when `tx_push` arrives while `tx_count` equals DEPTH, and `clr_w1c[2]` clears it. A push below DEPTH does not set it.
- R7: `status[6]` (CTS change) is a sticky flag. It is set one edge after `cts_n` takes a value different from the one sampled at the previous edge after reset, and `clr_w1c[3]` clears it.
- R8: `rx_flush` clears both RX error flags and restarts the timeout window. `tx_flush` clears the TX error flag. Neither flush touches the other side's flags.
- R9: When a flag's set event and any of its clears occur in the same cycle, the flag ends the cycle set.
- R10: `irq` equals the OR of (`status` AND `irq_en`) as it stood at the previous clock edge.
- R11: After reset every sticky flag is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle oversampling tick |
| cfg_wlen | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_os8 | input | 1 | Oversampling by 8 instead of 16 |
| rx_count | input | CW | RX FIFO occupancy |
| rx_push | input | 1 | RX FIFO write strobe |
| rx_pop | input | 1 | RX FIFO read strobe |
| rx_trig | input | CW | RX level trigger |
| rx_frame_err | input | 1 | Framing error strobe |
| rx_par_err | input | 1 | Parity error strobe |
| rx_brk_err | input | 1 | Break strobe |
| rx_overrun | input | 1 | RX overrun strobe |
| rx_flush | input | 1 | RX FIFO clear strobe |
| tx_count | input | CW | TX FIFO occupancy |
| tx_push | input | 1 | TX FIFO write attempt |
| tx_busy | input | 1 | Transmitter shifting |
| tx_trig | input | CW | TX level trigger |
| tx_flush | input | 1 | TX FIFO clear strobe |
| cts_n | input | 1 | Clear-to-send, active low |
| irq_en | input | 7 | Per-cause enable mask |
| clr_w1c | input | 4 | Write-one-to-clear strobes |
| status | output | 7 | Raw cause vector |
| irq | output | 1 | Registered combined interrupt |

## Verification
The level and TX-empty causes are driven with random FIFO counts, trigger levels and busy values. These runs separate the RX comparison (greater-or-equal) from the TX comparison (less-or-equal), and they show that a busy transmitter blocks TX empty. The same random vectors, with random enable masks, check that the enable masking and the one-cycle delay on `irq` are right. The timeout is checked directly in two frame configurations, one cycle before and one cycle after the expected edge. Directed tests also cover the cases where activity or a flush restarts the window and where an empty FIFO never times out. Further directed sequences pair each sticky flag with its own clear and with the clears of its neighbours, in the same cycle and in separate cycles, to tell the clears apart and to show that a set wins over a clear in the same cycle.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  // cause bit positions in the status vector
  localparam int NCAUSE  = 7;
  localparam int C_RXLVL = 0;
  localparam int C_RXERR = 1;
  localparam int C_RXTMO = 2;
  localparam int C_TXLVL = 3;
  localparam int C_TXERR = 4;
  localparam int C_TXEMP = 5;
  localparam int C_CTS   = 6;

  // sticky flags and their clear strobe positions
  localparam int NCLR     = 4;
  localparam int K_RXLINE = 0;
  localparam int K_RXOVR  = 1;
  localparam int K_TXOVR  = 2;
  localparam int K_CTS    = 3;

  // longest frame: start, 8 data, parity, 2 stop, times 16
  localparam int unsigned MAX_CHAR_TICKS = 12 * 16;

  // baud ticks in one character for the given frame shape
  function automatic int unsigned char_ticks(input logic [1:0] wlen,
                                             input logic par_en,
                                             input logic stop2,
                                             input logic os8);
    int unsigned bits;
    bits = 32'd7 + 32'(wlen) + 32'(par_en) + 32'(stop2);
    return os8 ? (bits << 3) : (bits << 4);
  endfunction
endpackage

// File: rtl/uirq_flag.sv
module uirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/uirq_tmo.sv
module uirq_tmo
  import uirq_pkg::*;
#(
  parameter int CW    = 5,
  parameter int CHARS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [1:0]    wlen,
  input  logic          par_en,
  input  logic          stop2,
  input  logic          os8,
  input  logic [CW-1:0] rx_count,
  input  logic          rx_act,
  input  logic          flush,
  output logic          tmo_o
);
  localparam int unsigned LIMIT_MAX = CHARS * MAX_CHAR_TICKS;
  localparam int TW = $clog2(LIMIT_MAX + 1);

  logic [TW-1:0] limit;
  logic [TW-1:0] cnt;
  logic          restart;
  logic          has_data;

  assign limit    = TW'(32'(CHARS) * char_ticks(wlen, par_en, stop2, os8));
  assign has_data = (rx_count != '0);
  assign restart  = rx_act | flush | !has_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (restart)             cnt <= '0;
    else if (tick && cnt < limit) cnt <= cnt + 1'b1;
  end

  assign tmo_o = has_data && (cnt >= limit);

  p_tmo_needs_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |-> (rx_count != '0));
  p_tmo_quiet_after_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_act || flush) |=> !tmo_o);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int CW        = $clog2(DEPTH + 1),
  parameter int TMO_CHARS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_stop2,
  input  logic              cfg_os8,
  input  logic [CW-1:0]     rx_count,
  input  logic              rx_push,
  input  logic              rx_pop,
  input  logic [CW-1:0]     rx_trig,
  input  logic              rx_frame_err,
  input  logic              rx_par_err,
  input  logic              rx_brk_err,
  input  logic              rx_overrun,
  input  logic              rx_flush,
  input  logic [CW-1:0]     tx_count,
  input  logic              tx_push,
  input  logic              tx_busy,
  input  logic [CW-1:0]     tx_trig,
  input  logic              tx_flush,
  input  logic              cts_n,
  input  logic [NCAUSE-1:0] irq_en,
  input  logic [NCLR-1:0]   clr_w1c,
  output logic [NCAUSE-1:0] status,
  output logic              irq
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  // CTS edge detection
  logic cts_q, cts_seen, cts_chg;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_q    <= 1'b1;
      cts_seen <= 1'b0;
    end else begin
      cts_q    <= cts_n;
      cts_seen <= 1'b1;
    end
  end
  assign cts_chg = cts_seen & (cts_n ^ cts_q);

  // sticky event flags
  logic [NCLR-1:0] fl_set, fl_clr, fl_q;
  logic            tx_lost;
  assign tx_lost = tx_push && (tx_count >= FULL);

  always_comb begin
    fl_set           = '0;
    fl_clr           = '0;
    fl_set[K_RXLINE] = rx_frame_err | rx_par_err | rx_brk_err;
    fl_clr[K_RXLINE] = clr_w1c[K_RXLINE] | rx_flush;
    fl_set[K_RXOVR]  = rx_overrun;
    fl_clr[K_RXOVR]  = clr_w1c[K_RXOVR] | rx_flush;
    fl_set[K_TXOVR]  = tx_lost;
    fl_clr[K_TXOVR]  = clr_w1c[K_TXOVR] | tx_flush;
    fl_set[K_CTS]    = cts_chg;
    fl_clr[K_CTS]    = clr_w1c[K_CTS];
  end

  for (genvar gi = 0; gi < NCLR; gi++) begin : g_flag
    uirq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (fl_set[gi]),
      .clr_i  (fl_clr[gi]),
      .flag_o (fl_q[gi])
    );
  end

  // receive timeout
  logic rx_tmo;
  uirq_tmo #(.CW(CW), .CHARS(TMO_CHARS)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (baud_tick),
    .wlen     (cfg_wlen),
    .par_en   (cfg_par_en),
    .stop2    (cfg_stop2),
    .os8      (cfg_os8),
    .rx_count (rx_count),
    .rx_act   (rx_push | rx_pop),
    .flush    (rx_flush),
    .tmo_o    (rx_tmo)
  );

  // raw cause vector
  always_comb begin
    status          = '0;
    status[C_RXLVL] = (rx_count >= rx_trig);
    status[C_RXERR] = fl_q[K_RXLINE] | fl_q[K_RXOVR];
    status[C_RXTMO] = rx_tmo;
    status[C_TXLVL] = (tx_count <= tx_trig);
    status[C_TXERR] = fl_q[K_TXOVR];
    status[C_TXEMP] = (tx_count == '0) && !tx_busy;
    status[C_CTS]   = fl_q[K_CTS];
  end

  // combined, registered interrupt line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(status & irq_en);
  end

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |=> !irq);
  p_txemp_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !status[C_TXEMP]);
  p_txerr_from_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_count < FULL && !status[C_TXERR]) |=> !status[C_TXERR]);
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  localparam int DEPTH = 16;
  localparam int CW    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic [1:0] cfg_wlen = 2'd0;
  logic cfg_par_en = 1'b0, cfg_stop2 = 1'b0, cfg_os8 = 1'b1;
  logic [CW-1:0] rx_count = '0, rx_trig = 5'd1, tx_count = '0, tx_trig = 5'd4;
  logic rx_push = 0, rx_pop = 0, rx_frame_err = 0, rx_par_err = 0, rx_brk_err = 0;
  logic rx_overrun = 0, rx_flush = 0, tx_push = 0, tx_busy = 0, tx_flush = 0, cts_n = 1;
  logic [6:0] irq_en = '0;
  logic [3:0] clr_w1c = '0;
  logic [6:0] status;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  uart_irq_ctrl #(.DEPTH(DEPTH)) i_uart_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_wlen(cfg_wlen),
    .cfg_par_en(cfg_par_en), .cfg_stop2(cfg_stop2), .cfg_os8(cfg_os8),
    .rx_count(rx_count), .rx_push(rx_push), .rx_pop(rx_pop), .rx_trig(rx_trig),
    .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err), .rx_brk_err(rx_brk_err),
    .rx_overrun(rx_overrun), .rx_flush(rx_flush), .tx_count(tx_count),
    .tx_push(tx_push), .tx_busy(tx_busy), .tx_trig(tx_trig), .tx_flush(tx_flush),
    .cts_n(cts_n), .irq_en(irq_en), .clr_w1c(clr_w1c), .status(status), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // live causes (bits 0, 3, 5) from the requirement text
  function automatic logic [6:0] live_causes(input int rc, input int rt, input int tc,
                                             input int tt, input bit busy);
    logic [6:0] v = '0;
    v[0] = rc >= rt;
    v[3] = !(tc > tt);
    v[5] = (tc == 0) && (busy == 1'b0);
    return v;
  endfunction

  function automatic int tmo_ticks(input int wl, input bit par, input bit st2, input bit os8);
    int per_char = 1 + (5 + wl) + (par ? 1 : 0) + (st2 ? 2 : 1);
    return 4 * per_char * (os8 ? 8 : 16);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // timeout window check for one frame shape
  task automatic tmo_case(input string tag, input int lim);
    rx_count = 5'd1; rx_push = 1'b1; baud_tick = 1'b1;
    cyc(1); rx_push = 1'b0;
    cyc(lim - 1);
    check({tag, " R3 before window end"}, 32'(status[2]), 32'd0);
    cyc(1);
    check({tag, " R3 at window end"}, 32'(status[2]), 32'd1);
    cyc(1);
    check({tag, " R10 irq from timeout"}, 32'(irq), 32'd1);
    rx_pop = 1'b1; cyc(1); rx_pop = 1'b0;
    check({tag, " R3 pop restarts"}, 32'(status[2]), 32'd0);
  endtask

  initial begin
    int lim;
    void'($urandom(32'd20240611));
    cyc(3);
    check("R11 irq in reset", 32'(irq), 32'd0);
    rst_n = 1'b1;
    cyc(2);
    check("R11 status after reset", 32'(status), 32'(live_causes(0, 1, 0, 4, 0)));
    check("R11 irq after reset", 32'(irq), 32'd0);

    // random live causes and masking (R1 R2 R4 R10)
    for (int i = 0; i < 300; i++) begin
      logic [6:0] e;
      rx_count = CW'($urandom_range(0, DEPTH));
      rx_trig  = CW'($urandom_range(0, DEPTH));
      tx_count = CW'($urandom_range(0, DEPTH));
      tx_trig  = CW'($urandom_range(0, DEPTH));
      tx_busy  = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) tx_count = '0;
      irq_en   = 7'($urandom);
      #1;
      e = live_causes(int'(rx_count), int'(rx_trig), int'(tx_count), int'(tx_trig), tx_busy);
      check("R1 rx level", 32'(status[0]), 32'(e[0]));
      check("R2 tx level", 32'(status[3]), 32'(e[3]));
      check("R4 tx empty", 32'(status[5]), 32'(e[5]));
      cyc(1);
      check("R10 irq masked or", 32'(irq), 32'(|(e & irq_en)));
      rx_count = '0;
    end
    irq_en = '0; tx_busy = 1'b1; rx_trig = 5'd17; tx_trig = '0; tx_count = 5'd3;
    cyc(2);
    check("R1 R2 R4 quiet", 32'(status), 32'd0);

    // timeout (R3, R8)
    irq_en = 7'b0000100;
    lim = tmo_ticks(0, 0, 0, 1);
    tmo_case("5N1x8", lim);
    rx_count = '0; cyc(1);
    cfg_wlen = 2'd3; cfg_par_en = 1'b1; cfg_stop2 = 1'b1; cfg_os8 = 1'b0;
    tmo_case("8P2x16", tmo_ticks(3, 1, 1, 0));
    rx_count = '0; cyc(1);
    cfg_wlen = 2'd0; cfg_par_en = 1'b0; cfg_stop2 = 1'b0; cfg_os8 = 1'b1;
    rx_count = 5'd2; rx_push = 1'b1; cyc(1); rx_push = 1'b0;
    cyc(100);
    rx_flush = 1'b1; cyc(1); rx_flush = 1'b0;
    cyc(lim - 1);
    check("R8 rx flush restarts timeout", 32'(status[2]), 32'd0);
    rx_count = '0; cyc(lim + 50);
    check("R3 empty fifo never times out", 32'(status[2]), 32'd0);
    baud_tick = 1'b0; irq_en = '0; cyc(1);

    // rx errors (R5 R8 R9)
    rx_frame_err = 1'b1; cyc(1); rx_frame_err = 1'b0;
    check("R5 frame error sets", 32'(status[1]), 32'd1);
    clr_w1c = 4'b0010; cyc(1); clr_w1c = '0;
    check("R5 overrun clear keeps line error", 32'(status[1]), 32'd1);
    clr_w1c = 4'b0001; cyc(1); clr_w1c = '0;
    check("R5 line clear", 32'(status[1]), 32'd0);
    rx_brk_err = 1'b1; cyc(1); rx_brk_err = 1'b0;
    check("R5 break sets", 32'(status[1]), 32'd1);
    clr_w1c = 4'b0001; cyc(1); clr_w1c = '0;
    rx_overrun = 1'b1; cyc(1); rx_overrun = 1'b0;
    check("R5 overrun sets", 32'(status[1]), 32'd1);
    clr_w1c = 4'b0001; cyc(1); clr_w1c = '0;
    check("R5 line clear keeps overrun", 32'(status[1]), 32'd1);
    clr_w1c = 4'b0010; cyc(1); clr_w1c = '0;
    check("R5 overrun clear", 32'(status[1]), 32'd0);
    rx_par_err = 1'b1; clr_w1c = 4'b0001; cyc(1); rx_par_err = 1'b0; clr_w1c = '0;
    check("R9 set beats w1c", 32'(status[1]), 32'd1);

    // tx overflow (R6 R8 R9)
    tx_count = 5'd15; tx_push = 1'b1; cyc(1); tx_push = 1'b0;
    check("R6 push below full", 32'(status[4]), 32'd0);
    tx_count = 5'd16; tx_push = 1'b1; cyc(1); tx_push = 1'b0;
    check("R6 push at full", 32'(status[4]), 32'd1);
    rx_flush = 1'b1; cyc(1); rx_flush = 1'b0;
    check("R8 rx flush clears rx error", 32'(status[1]), 32'd0);
    check("R8 rx flush leaves tx error", 32'(status[4]), 32'd1);
    rx_overrun = 1'b1; cyc(1); rx_overrun = 1'b0;
    tx_flush = 1'b1; cyc(1); tx_flush = 1'b0;
    check("R8 tx flush clears tx error", 32'(status[4]), 32'd0);
    check("R8 tx flush leaves rx error", 32'(status[1]), 32'd1);
    tx_push = 1'b1; tx_flush = 1'b1; cyc(1); tx_push = 1'b0; tx_flush = 1'b0;
    check("R9 set beats flush", 32'(status[4]), 32'd1);
    clr_w1c = 4'b0100; cyc(1); clr_w1c = '0;
    check("R6 w1c clears", 32'(status[4]), 32'd0);

    // CTS change (R7 R10)
    check("R7 idle no change", 32'(status[6]), 32'd0);
    cts_n = 1'b0; cyc(1);
    check("R7 falling edge", 32'(status[6]), 32'd1);
    clr_w1c = 4'b1000; cyc(1); clr_w1c = '0; cyc(2);
    check("R7 clear, steady", 32'(status[6]), 32'd0);
    cts_n = 1'b1; cyc(1);
    check("R7 rising edge", 32'(status[6]), 32'd1);
    irq_en = 7'b1000000;
    #1 check("R10 irq still old", 32'(irq), 32'd0);
    cyc(1);
    check("R10 irq one edge later", 32'(irq), 32'd1);
    irq_en = 7'b0111111; cyc(1);
    check("R10 mask removes", 32'(irq), 32'(|(status & irq_en)));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule